// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block connects a single-request synchronous bus to an external asynchronous static RAM of 256K words by 16 bits. The requester presents a word address, write data, a two-bit byte-enable mask and a direction flag. The block latches the request and sequences the RAM's active-low strobes: chip select, output enable, write enable, and one select for each byte lane. It holds the strobes long enough to cover the RAM's access time. When the access ends it raises a one-clock acknowledge, and on reads it returns the data at the same time.

The hold time is counted in clocks. It is worked out at elaboration from two parameters, the clock period in picoseconds and the RAM speed grade in nanoseconds, as the ceiling of access time over clock period with a floor of one.

A read keeps output enable low for the whole wait window. A write has three phases:
- The data lanes are driven for one setup cycle.
- Write enable is pulled low for the wait window.
- The lanes are held for one more cycle after write enable rises.

The shared data bus is exposed as separate outgoing data, per-lane drive enables and incoming data. The pad-level tristate therefore sits outside the block.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, and whenever no access is in progress, chip select, output enable, write enable and both byte selects are high (inactive), both data drive enables are 0, and ack is 0.
- R2: The wait count W equals the ceiling of (SPEED_GRADE_NS*1000 / CLK_PERIOD_PS), at least 1. A read accepted at a clock edge raises ack W edges later. A write raises ack W+2 edges later.
- R3: For a write, the enabled lanes are driven one cycle before write enable falls, write enable stays low for exactly W cycles, and the lanes stay driven with chip select low for one cycle after write enable rises.
- R4: Write enable and output enable are never low together. The controller never drives a data lane while output enable is low.
- R5: Mask bit 0 selects the lower lane (data bits 7:0, lower select pin). Mask bit 1 selects the upper lane (data bits 15:8, upper select pin). A write changes only the selected bytes in the RAM.
- R6: Read data returned with ack holds the RAM bytes for selected lanes. Bytes of unselected lanes read as 0x00.
- R7: A request with mask 2'b00 completes with a normal ack and never pulls either byte select low. A write with this mask leaves the RAM unchanged.
- R8: A request presented while busy is high is ignored. It is not performed later and does not disturb the address of the access in progress.
- R9: ack is high for exactly one clock per accepted request.
- R10: While chip select is high, neither the controller nor the RAM drives the data bus. While output enable and write enable are both high, the RAM does not drive the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enable mask, bit 0 lower lane, bit 1 upper lane |
| busy | output | 1 | Access in progress |
| ack | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Read data, valid with ack |
| mem_addr | output | 18 | RAM address |
| mem_cs_n | output | 1 | RAM chip select, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_lb_n | output | 1 | RAM lower byte select, active low |
| mem_ub_n | output | 1 | RAM upper byte select, active low |
| mem_dq_o | output | 16 | Data driven toward the RAM |
| mem_dq_oe | output | 2 | Per-lane drive enable for mem_dq_o |
| mem_dq_i | input | 16 | Data bus as seen at the pads |

## Verification
The assertions assume the clock-period parameter matches the real clock. They also assume the RAM never drives the bus while write enable is low, so a lane conflict can only come from the controller. They further assume reset is not applied in the middle of an access in a way that later checks would need to see.

The stimulus drives inputs only on falling edges. It keeps mem_dq_i resolved by a behavioural RAM that honours the truth table, and it holds each request until acceptance. Deliberate extra requests are injected only while busy is high, to exercise the ignore rule.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    localparam int ADDR_W = 18;
    localparam int LANES  = 2;
    localparam int LANE_W = 8;
    localparam int DATA_W = LANES * LANE_W;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD_ACC   = 3'd1,
        ST_WR_SETUP = 3'd2,
        ST_WR_PULSE = 3'd3,
        ST_WR_HOLD  = 3'd4,
        ST_DONE     = 3'd5
    } seq_state_e;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [LANES-1:0]  be;
    } acc_req_t;

    function automatic int wait_cycles(input int access_ps, input int clk_ps);
        int w;
        w = (access_ps + clk_ps - 1) / clk_ps;
        if (w < 1) w = 1;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] lane_mask(input logic [LANES-1:0] be);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < LANES; i++) m[i*LANE_W +: LANE_W] = {LANE_W{be[i]}};
        return m;
    endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
    parameter int CYCLES = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= LOAD;
        else if (cnt != '0) cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= LOAD);

    a_r2_reload_when_idle: assert property (@(posedge clk) disable iff (rst)
        !run |=> cnt == LOAD);
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic       req_we,
    input  logic       expired,
    output seq_state_e state,
    output logic       accept,
    output logic       running
);
    seq_state_e nxt;

    assign accept  = (state == ST_IDLE) && req_valid;
    assign running = (state == ST_RD_ACC) || (state == ST_WR_PULSE);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (req_valid) nxt = req_we ? ST_WR_SETUP : ST_RD_ACC;
            ST_RD_ACC:   if (expired) nxt = ST_DONE;
            ST_WR_SETUP: nxt = ST_WR_PULSE;
            ST_WR_PULSE: if (expired) nxt = ST_WR_HOLD;
            ST_WR_HOLD:  nxt = ST_DONE;
            ST_DONE:     nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    a_r9_done_then_idle: assert property (@(posedge clk) disable iff (rst)
        state == ST_DONE |=> state == ST_IDLE);

    a_r3_setup_then_pulse: assert property (@(posedge clk) disable iff (rst)
        state == ST_WR_SETUP |=> state == ST_WR_PULSE);

    a_r3_hold_then_done: assert property (@(posedge clk) disable iff (rst)
        state == ST_WR_HOLD |=> state == ST_DONE);
endmodule

// File: rtl/sram_pin_drive.sv
module sram_pin_drive
    import sram_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  seq_state_e        state,
    input  logic              accept,
    input  logic              expired,
    input  acc_req_t          req_in,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [LANES-1:0]  lane_sel_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic [LANES-1:0]  mem_dq_oe,
    output logic [DATA_W-1:0] rdata,
    output logic              ack
);
    acc_req_t req_q;
    logic     active;
    logic     wr_phase;

    always_ff @(posedge clk) begin
        if (rst)         req_q <= '0;
        else if (accept) req_q <= req_in;
    end

    always_ff @(posedge clk) begin
        if (rst)                                rdata <= '0;
        else if (state == ST_RD_ACC && expired) rdata <= mem_dq_i & lane_mask(req_q.be);
    end

    assign active   = (state == ST_RD_ACC) || (state == ST_WR_SETUP) ||
                      (state == ST_WR_PULSE) || (state == ST_WR_HOLD);
    assign wr_phase = (state == ST_WR_SETUP) || (state == ST_WR_PULSE) ||
                      (state == ST_WR_HOLD);

    assign mem_cs_n = !active;
    assign mem_oe_n = !(state == ST_RD_ACC);
    assign mem_we_n = !(state == ST_WR_PULSE);
    assign mem_addr = req_q.addr;
    assign mem_dq_o = req_q.wdata;
    assign ack      = (state == ST_DONE);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_sel_n[g] = !(active && req_q.be[g]);
        assign mem_dq_oe[g]  = wr_phase && req_q.be[g];
    end

    a_r4_no_drive_on_read: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> mem_dq_oe == '0);

    a_r4_we_excludes_oe: assert property (@(posedge clk) disable iff (rst)
        !(!mem_we_n && !mem_oe_n));

    a_r3_data_setup: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_we_n) |-> mem_dq_oe == $past(mem_dq_oe) && !$past(mem_cs_n));

    a_r3_data_hold: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> mem_dq_oe == $past(mem_dq_oe) && !mem_cs_n);

    a_r10_standby_quiet: assert property (@(posedge clk) disable iff (rst)
        mem_cs_n |-> mem_dq_oe == '0 && mem_we_n && mem_oe_n && (&lane_sel_n));

    a_r9_ack_pulse: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int CLK_PERIOD_PS  = 10000,
    parameter int SPEED_GRADE_NS = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_be,
    output logic              busy,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic [LANES-1:0]  mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);
    localparam int ACCESS_PS = SPEED_GRADE_NS * 1000;
    localparam int WAIT_CYC  = wait_cycles(ACCESS_PS, CLK_PERIOD_PS);

    seq_state_e       state;
    logic             accept;
    logic             running;
    logic             expired;
    logic [LANES-1:0] lane_sel_n;
    acc_req_t         req_in;

    assign req_in = '{we: req_we, addr: req_addr, wdata: req_wdata, be: req_be};

    sram_seq_fsm u_fsm (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
        .expired(expired), .state(state), .accept(accept), .running(running)
    );

    sram_wait_timer #(.CYCLES(WAIT_CYC)) u_timer (
        .clk(clk), .rst(rst), .run(running), .expired(expired)
    );

    sram_pin_drive u_pins (
        .clk(clk), .rst(rst), .state(state), .accept(accept), .expired(expired),
        .req_in(req_in), .mem_dq_i(mem_dq_i), .mem_addr(mem_addr),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .lane_sel_n(lane_sel_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
        .rdata(rdata), .ack(ack)
    );

    assign busy     = (state != ST_IDLE);
    assign mem_lb_n = lane_sel_n[0];
    assign mem_ub_n = lane_sel_n[1];

    a_r8_addr_frozen_busy: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(mem_addr));

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> mem_cs_n && !ack && mem_dq_oe == '0);
endmodule

// File: tb/sram_async_model.sv
module sram_async_model (
    input  logic        cs_n,
    input  logic        oe_n,
    input  logic        we_n,
    input  logic        lb_n,
    input  logic        ub_n,
    input  logic [17:0] addr,
    input  logic [15:0] bus,
    output logic [1:0]  drv,
    output logic [15:0] dout
);
    logic [15:0] mem [int];

    function automatic logic [15:0] peek(input int a);
        return mem.exists(a) ? mem[a] : 16'h0000;
    endfunction

    always @(posedge we_n) begin
        if (!cs_n) begin
            logic [15:0] w;
            w = peek(int'(addr));
            if (!lb_n) w[7:0]  = bus[7:0];
            if (!ub_n) w[15:8] = bus[15:8];
            mem[int'(addr)] = w;
        end
    end

    always @(negedge oe_n or addr) dout = peek(int'(addr));

    assign drv[0] = !cs_n && we_n && !oe_n && !lb_n;
    assign drv[1] = !cs_n && we_n && !oe_n && !ub_n;
endmodule

// File: tb/sram_lane_ctrl_tb.sv
module sram_lane_ctrl_tb;
    localparam int W_EXP = 3; // ceil(10000 ps / 4000 ps)

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic        req_valid = 0, req_we = 0;
    logic [17:0] req_addr = 0;
    logic [15:0] req_wdata = 0;
    logic [1:0]  req_be = 0;
    logic        busy, ack;
    logic [15:0] rdata, mem_dq_o, mem_dq_i, model_o;
    logic [17:0] mem_addr;
    logic        mem_cs_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n;
    logic [1:0]  mem_dq_oe, model_drv;

    int tests = 0, fails = 0, cyc = 0, hiz_viol = 0, conflict_viol = 0;
    logic [15:0] sb [int];

    sram_lane_ctrl #(.CLK_PERIOD_PS(4000), .SPEED_GRADE_NS(10)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .busy(busy), .ack(ack), .rdata(rdata), .mem_addr(mem_addr),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_dq_o(mem_dq_o),
        .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    sram_async_model u_ram (
        .cs_n(mem_cs_n), .oe_n(mem_oe_n), .we_n(mem_we_n), .lb_n(mem_lb_n),
        .ub_n(mem_ub_n), .addr(mem_addr), .bus(mem_dq_i), .drv(model_drv), .dout(model_o)
    );

    assign mem_dq_i[7:0]  = mem_dq_oe[0] ? mem_dq_o[7:0]  : model_drv[0] ? model_o[7:0]  : 8'h00;
    assign mem_dq_i[15:8] = mem_dq_oe[1] ? mem_dq_o[15:8] : model_drv[1] ? model_o[15:8] : 8'h00;

    function automatic logic [15:0] bmask(input logic [1:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction

    function automatic logic [15:0] sb_get(input int a);
        return sb.exists(a) ? sb[a] : 16'h0000;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // R10 bus monitor, every clock
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_cs_n && (mem_dq_oe != 0 || model_drv != 0)) hiz_viol++;
            if (mem_oe_n && mem_we_n && model_drv != 0) hiz_viol++;
            if ((mem_dq_oe & model_drv) != 0) conflict_viol++;
            if (!mem_oe_n && mem_dq_oe != 0) conflict_viol++;
            if (!mem_oe_n && !mem_we_n) conflict_viol++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            tests++; fails++;
            $display("FAIL R2 watchdog actual=%0d expected=%0d", cyc, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic access(input bit we, input int a, input logic [15:0] d,
                          input logic [1:0] be, input bit inject,
                          output logic [15:0] rd);
        int   expk   = we ? W_EXP + 3 : W_EXP + 1;
        bit   lat_ok = 1, order_ok = 1, sel_bad = 0;
        int   we_low = 0;
        logic prev_we = 1;
        logic [1:0] prev_oe = 0;
        rd = 0;
        @(negedge clk);
        req_valid = 1; req_we = we; req_addr = 18'(a); req_wdata = d; req_be = be;
        for (int k = 1; k <= expk + 2; k++) begin
            @(negedge clk);
            if (k == 1) begin
                if (inject) begin
                    req_we = 1; req_addr = 18'(a + 2); req_wdata = ~d; req_be = 2'b11;
                end else req_valid = 0;
            end
            if (k == expk) req_valid = 0;
            if (ack !== (k == expk)) lat_ok = 0;
            if (k == expk) rd = rdata;
            if (!mem_we_n) we_low++;
            if (prev_we && !mem_we_n && prev_oe != mem_dq_oe) order_ok = 0;
            if (!prev_we && mem_we_n && (prev_oe != mem_dq_oe || mem_cs_n)) order_ok = 0;
            if (be == 2'b00 && (!mem_lb_n || !mem_ub_n)) sel_bad = 1;
            prev_we = mem_we_n; prev_oe = mem_dq_oe;
        end
        req_valid = 0;
        check(lat_ok, "R2", we ? "write ack timing (R9 single pulse)" : "read ack timing (R9 single pulse)",
              lat_ok, 1);
        if (we) begin
            check(we_low == W_EXP, "R3", "write enable low cycles", we_low, W_EXP);
            check(order_ok, "R3", "data setup/hold around write enable", order_ok, 1);
            sb[a] = (sb_get(a) & ~bmask(be)) | (d & bmask(be));
        end
        if (be == 2'b00) check(!sel_bad, "R7", "byte select with empty mask", sel_bad, 0);
    endtask

    task automatic read_chk(input int a, input logic [1:0] be, input string req);
        logic [15:0] got, expv;
        access(0, a, 16'h0, be, 0, got);
        expv = sb_get(a) & bmask(be);
        check(got == expv, req, "read data", got, expv);
    endtask

    initial begin
        logic [15:0] dummy;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check(mem_cs_n && mem_oe_n && mem_we_n && mem_lb_n && mem_ub_n &&
              mem_dq_oe == 0 && !ack && !busy, "R1", "idle pins after reset",
              {mem_cs_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe, ack}, 8'hF8);

        // R5 full word then single lanes
        access(1, 5, 16'h1234, 2'b11, 0, dummy);
        read_chk(5, 2'b11, "R5");
        access(1, 5, 16'hABCD, 2'b10, 0, dummy);
        read_chk(5, 2'b11, "R5");
        access(1, 18'h3FFFF, 16'h5566, 2'b01, 0, dummy);
        read_chk(18'h3FFFF, 2'b01, "R5");
        // R6 unselected lane reads zero
        read_chk(18'h3FFFF, 2'b10, "R6");
        read_chk(5, 2'b01, "R6");

        // R7 empty mask: write ignored, read returns zero
        access(1, 5, 16'hFFFF, 2'b00, 0, dummy);
        read_chk(5, 2'b11, "R7");
        read_chk(5, 2'b00, "R7");

        // R8 requests while busy ignored
        access(1, 7, 16'h1111, 2'b11, 1, dummy);
        read_chk(9, 2'b11, "R8");
        read_chk(7, 2'b11, "R8");
        @(negedge clk);
        check(!busy && mem_cs_n, "R8", "no pending access after busy request",
              {busy, mem_cs_n}, 2'b01);

        // mixed patterns
        for (int i = 0; i < 8; i++) begin
            access(1, (i * 18'h1111) & 18'h3FFFF, 16'(16'hA5C3 ^ (i * 16'h0F1F)),
                   2'(i % 4), 0, dummy);
        end
        for (int i = 0; i < 8; i++) read_chk((i * 18'h1111) & 18'h3FFFF, 2'b11, "R5");

        @(negedge clk);
        check(hiz_viol == 0, "R10", "bus driven in standby/disabled", hiz_viol, 0);
        check(conflict_viol == 0, "R4", "drive while reading or strobe overlap", conflict_viol, 0);
        check(mem_cs_n && !ack && mem_dq_oe == 0, "R1", "idle pins at end",
              {mem_cs_n, ack, mem_dq_oe}, 4'b1000);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule